// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit IEEE 754 single-precision operands and returns a 32-bit single-precision product. It also returns two flags. One flag reports that the exponent ran past the largest finite value. The other reports that it fell below the smallest normal value. The block takes a pair of operands when `start` is high at a clock edge. One edge later it updates `product` and the flags together and pulses `done`.

The arithmetic follows the usual path. The sign is the exclusive-OR of the operand signs. The biased exponents are added and the bias is taken off once. The two 24-bit significands, hidden bits included, give a 48-bit product. That product is normalized by at most one position and then truncated to 23 fraction bits. Operand encodings with a zero exponent are taken as zero. Infinity and NaN operands take fixed paths. Subnormal results are not produced: they are flushed to a signed zero.

Top module: `fp_mul_unit`

## Requirements
- R1: The sign bit of a numeric result (zero, finite or infinity) is the exclusive-OR of bit 31 of the two operands.
- R2: For two normal operands with no overflow or underflow, the result exponent (bits 30:23) is the sum of the two operand exponents minus 127, when the significand product is below 2.
- R3: When bit 47 of the 48-bit significand product is set, the product is shifted right by one and the result exponent is one higher than in R2.
- R4: The result fraction is the 23 product bits just below the leading one; all lower bits are dropped without rounding.
- R5: A biased result exponent above 254 (after normalization) gives an infinity (exponent 255, fraction 0) with the R1 sign and raises `ovf`. Exactly 254 is a normal result.
- R6: A biased result exponent below 1 (after normalization) gives a zero with the R1 sign and raises `unf`. Exactly 1 is a normal result.
- R7: An operand whose exponent field is 0 counts as zero. If the other operand is finite, the result is a zero with the R1 sign and both flags stay low.
- R8: An infinity operand (exponent 255, fraction 0) times a finite nonzero or infinite operand gives an infinity with the R1 sign and both flags low.
- R9: Any NaN operand (exponent 255, nonzero fraction), or infinity times zero, gives 32'h7FC00000 with both flags low.
- R10: Operands are latched at the clock edge where `start` is high and the block is idle. `product`, `ovf` and `unf` update at the next edge, and `done` is high for exactly that one cycle. The outputs then hold until the next result.
- R11: A `start` during the computing cycle is ignored. Operand changes after the latching edge do not affect the result.
- R12: While `rst_n` is low, `product`, `ovf`, `unf` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe; latches the operands when idle |
| opA | input | 32 | First single-precision operand |
| opB | input | 32 | Second single-precision operand |
| product | output | 32 | Single-precision result |
| ovf | output | 1 | Overflow flag, valid with the result |
| unf | output | 1 | Underflow flag, valid with the result |
| done | output | 1 | One-cycle strobe marking a new result |

## Verification
Every result is due one clock edge after the edge that latched its `start`. `product`, `ovf`, `unf` and `done` all change at that second edge. `done` must be low again one edge later.

The bench drives inputs on the falling edge and checks `done` low at the falling edge just after the latch. It compares the full result at the next falling edge, then checks that `done` has dropped while the result holds.

The checker ties `done` to a `start` exactly two samples earlier. It takes the expected sign from the operands seen at that same sample.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  // Strobes from the sequencer to the arithmetic path
  typedef struct packed {
    logic loadOps;  // capture operands this edge
    logic capture;  // register the computed result this edge
  } fpm_strobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CALC = 1'b1
  } fpm_state_e;
endpackage

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output fpm_strobe_t strobes,
  output logic        done
);
  fpm_state_e state, stateNext;

  always_comb begin
    stateNext       = state;
    strobes.loadOps = 1'b0;
    strobes.capture = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        strobes.loadOps = 1'b1;
        stateNext       = ST_CALC;
      end
      ST_CALC: begin
        strobes.capture = 1'b1;
        stateNext       = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobes.capture;
    end
  end
endmodule

// File: rtl/fpm_datapath.sv
module fpm_datapath
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  fpm_strobe_t             strobes,
  input  logic [EXP_W+FRAC_W:0]   opA,
  input  logic [EXP_W+FRAC_W:0]   opB,
  output logic [EXP_W+FRAC_W:0]   product,
  output logic                    ovf,
  output logic                    unf
);
  localparam int WORD_W  = EXP_W + FRAC_W + 1;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int PROD_W  = 2 * SIG_W;
  localparam int SUM_W   = EXP_W + 2;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_TOP = (1 << EXP_W) - 1;
  localparam logic signed [SUM_W-1:0] MAX_FINITE = SUM_W'(EXP_TOP - 1);
  localparam logic signed [SUM_W-1:0] MIN_NORMAL = SUM_W'(1);
  localparam logic [EXP_W-1:0]  EXP_ONES = '1;
  localparam logic [FRAC_W-1:0] QNAN_FRAC = FRAC_W'(1) << (FRAC_W - 1);

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
  } fp_word_t;

  fp_word_t latA, latB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latA <= '0;
      latB <= '0;
    end else if (strobes.loadOps) begin
      latA <= opA;
      latB <= opB;
    end
  end

  // Operand classes, one generate-style pair per operand
  logic [1:0] isZero, isInf, isNan;
  fp_word_t   ops [2];
  assign ops[0] = latA;
  assign ops[1] = latB;

  for (genvar k = 0; k < 2; k++) begin : g_class
    assign isZero[k] = (ops[k].expo == '0);
    assign isInf[k]  = (ops[k].expo == EXP_ONES) && (ops[k].frac == '0);
    assign isNan[k]  = (ops[k].expo == EXP_ONES) && (ops[k].frac != '0);
  end

  // Significand product and normalization
  logic [SIG_W-1:0]  sigA, sigB;
  logic [PROD_W-1:0] sigProd;
  logic              prodHigh;
  logic [FRAC_W-1:0] fracNorm;
  logic signed [SUM_W-1:0] expNorm;
  logic              resSign;

  assign sigA     = {1'b1, latA.frac};
  assign sigB     = {1'b1, latB.frac};
  assign sigProd  = PROD_W'(sigA) * PROD_W'(sigB);
  assign prodHigh = sigProd[PROD_W-1];
  assign fracNorm = prodHigh ? FRAC_W'(sigProd >> SIG_W)
                             : FRAC_W'(sigProd >> (SIG_W - 1));
  assign expNorm  = $signed(SUM_W'(latA.expo)) + $signed(SUM_W'(latB.expo))
                  - $signed(SUM_W'(BIAS)) + $signed(SUM_W'(prodHigh));
  assign resSign  = latA.sign ^ latB.sign;

  // Result selection, special operands first
  fp_word_t resNext;
  logic     ovfNext, unfNext;

  always_comb begin
    resNext = '{sign: resSign, expo: fracNormExp(expNorm), frac: fracNorm};
    ovfNext = 1'b0;
    unfNext = 1'b0;
    if ((|isNan) || ((|isInf) && (|isZero))) begin
      resNext = '{sign: 1'b0, expo: EXP_ONES, frac: QNAN_FRAC};
    end else if (|isInf) begin
      resNext = '{sign: resSign, expo: EXP_ONES, frac: '0};
    end else if (|isZero) begin
      resNext = '{sign: resSign, expo: '0, frac: '0};
    end else if (expNorm > MAX_FINITE) begin
      resNext = '{sign: resSign, expo: EXP_ONES, frac: '0};
      ovfNext = 1'b1;
    end else if (expNorm < MIN_NORMAL) begin
      resNext = '{sign: resSign, expo: '0, frac: '0};
      unfNext = 1'b1;
    end
  end

  function automatic logic [EXP_W-1:0] fracNormExp(input logic signed [SUM_W-1:0] e);
    return EXP_W'(e);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      product <= '0;
      ovf     <= 1'b0;
      unf     <= 1'b0;
    end else if (strobes.capture) begin
      product <= WORD_W'(resNext);
      ovf     <= ovfNext;
      unf     <= unfNext;
    end
  end
endmodule

// File: rtl/fp_mul_unit.sv
module fp_mul_unit
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  output logic [EXP_W+FRAC_W:0] product,
  output logic                  ovf,
  output logic                  unf,
  output logic                  done
);
  fpm_strobe_t strobes;

  fpm_ctrl i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .strobes (strobes),
    .done    (done)
  );

  fpm_datapath #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W)
  ) i_datapath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .product (product),
    .ovf     (ovf),
    .unf     (unf)
  );
endmodule

// File: rtl/fp_mul_unit_chk.sv
module fp_mul_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic [31:0] product,
  input logic        ovf,
  input logic        unf,
  input logic        done
);
  logic resIsNan;
  assign resIsNan = (product[30:23] == 8'hFF) && (product[22:0] != '0);

  // R5 R6: the two range flags never rise together
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));

  // R5: overflow always comes with an infinity encoding
  a_r5_ovf_inf: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (product[30:0] == 31'h7F800000));

  // R6: underflow always comes with a zero encoding
  a_r6_unf_zero: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> (product[30:0] == 31'h0));

  // R10: done lasts a single cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: each done follows a start two samples earlier
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 2));

  // R1: numeric results carry the XOR of the latched signs
  a_r1_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !resIsNan) |-> (product[31] == $past(opA[31] ^ opB[31], 2)));

  // R9: NaN results are always the canonical quiet pattern, flags low
  a_r9_nan_canon: assert property (@(posedge clk) disable iff (!rst_n)
    (done && resIsNan) |-> (product == 32'h7FC00000 && !ovf && !unf));
endmodule

bind fp_mul_unit fp_mul_unit_chk i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .opA     (opA),
  .opB     (opB),
  .product (product),
  .ovf     (ovf),
  .unf     (unf),
  .done    (done)
);

// File: tb/test_fp_mul_unit.sv
module test_fp_mul_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] product;
  logic        ovf, unf, done;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  fp_mul_unit i_fp_mul_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .opA(opA), .opB(opB),
    .product(product), .ovf(ovf), .unf(unf), .done(done)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] p;
    logic        o;
    logic        u;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{32'h3F800000, 32'h3F800000, 32'h3F800000, 1'b0, 1'b0, 8'd2},  // R2 1*1
    '{32'h40000000, 32'h40400000, 32'h40C00000, 1'b0, 1'b0, 8'd2},  // R2 2*3
    '{32'h3FC00000, 32'h3FC00000, 32'h40100000, 1'b0, 1'b0, 8'd3},  // R3 1.5*1.5
    '{32'hC0000000, 32'h40400000, 32'hC0C00000, 1'b0, 1'b0, 8'd1},  // R1 -2*3
    '{32'hBF800000, 32'hBF800000, 32'h3F800000, 1'b0, 1'b0, 8'd1},  // R1 -1*-1
    '{32'h3F800001, 32'h3F800001, 32'h3F800002, 1'b0, 1'b0, 8'd4},  // R4 low bits dropped
    '{32'h3FFFFFFF, 32'h3FFFFFFF, 32'h407FFFFE, 1'b0, 1'b0, 8'd4},  // R4 with R3 shift
    '{32'h7F000000, 32'h40000000, 32'h7F800000, 1'b1, 1'b0, 8'd5},  // R5 overflow
    '{32'hFF000000, 32'h40000000, 32'hFF800000, 1'b1, 1'b0, 8'd5},  // R5 negative overflow
    '{32'h7F000000, 32'h3FC00000, 32'h7F400000, 1'b0, 1'b0, 8'd5},  // R5 exponent 254 kept
    '{32'h7F400000, 32'h3FC00000, 32'h7F800000, 1'b1, 1'b0, 8'd5},  // R5 overflow via shift
    '{32'h00800000, 32'h3F000000, 32'h00000000, 1'b0, 1'b1, 8'd6},  // R6 underflow
    '{32'h80800000, 32'h3F000000, 32'h80000000, 1'b0, 1'b1, 8'd6},  // R6 negative underflow
    '{32'h00800000, 32'h3F800000, 32'h00800000, 1'b0, 1'b0, 8'd6},  // R6 exponent 1 kept
    '{32'h00C00000, 32'h3F400000, 32'h00900000, 1'b0, 1'b0, 8'd6},  // R6 rescued by shift
    '{32'h00000000, 32'h40400000, 32'h00000000, 1'b0, 1'b0, 8'd7},  // R7 zero
    '{32'h80000000, 32'h40400000, 32'h80000000, 1'b0, 1'b0, 8'd7},  // R7 signed zero
    '{32'h00000001, 32'h40000000, 32'h00000000, 1'b0, 1'b0, 8'd7},  // R7 zero-exponent code
    '{32'h00000000, 32'h7F7FFFFF, 32'h00000000, 1'b0, 1'b0, 8'd7},  // R7 zero times huge
    '{32'h7F800000, 32'hC0000000, 32'hFF800000, 1'b0, 1'b0, 8'd8},  // R8 inf*-2
    '{32'hFF800000, 32'hFF800000, 32'h7F800000, 1'b0, 1'b0, 8'd8},  // R8 -inf*-inf
    '{32'h7F800000, 32'h00800000, 32'h7F800000, 1'b0, 1'b0, 8'd8},  // R8 inf*tiny no flag
    '{32'h7F800000, 32'h00000000, 32'h7FC00000, 1'b0, 1'b0, 8'd9},  // R9 inf*0
    '{32'h7FC12345, 32'h3F800000, 32'h7FC00000, 1'b0, 1'b0, 8'd9},  // R9 NaN operand
    '{32'h3F800000, 32'hFFFFFFFF, 32'h7FC00000, 1'b0, 1'b0, 8'd9}   // R9 negative NaN
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Issue one operation; result compared one edge after the latching edge
  task automatic runOp(input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] expP, input logic expO,
                       input logic expU, input string req);
    @(negedge clk);
    opA = a; opB = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R10", "done early", {35'b0, done}, 36'h0);
    @(negedge clk);
    check(done && product == expP && ovf == expO && unf == expU, req, "result",
          {1'b0, done, ovf, unf, product}, {1'b0, 1'b1, expO, expU, expP});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    // R12: reset state
    repeat (3) @(negedge clk);
    check(product == '0 && !ovf && !unf && !done, "R12", "reset outputs",
          {1'b0, done, ovf, unf, product}, 36'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      runOp(VECS[i].a, VECS[i].b, VECS[i].p, VECS[i].o, VECS[i].u,
            $sformatf("R%0d", VECS[i].req));
    end

    // R10: done drops after one cycle and the result holds
    runOp(32'h40000000, 32'h40400000, 32'h40C00000, 1'b0, 1'b0, "R10");
    @(negedge clk);
    check(!done && product == 32'h40C00000, "R10", "hold after done",
          {3'b0, done, product}, {4'b0, 32'h40C00000});
    opA = 32'h3F800000;
    @(negedge clk);
    check(!done && product == 32'h40C00000, "R10", "idle operand change",
          {3'b0, done, product}, {4'b0, 32'h40C00000});

    // R11: start during computing cycle and late operand change ignored
    @(negedge clk);
    opA = 32'h3FC00000; opB = 32'h3FC00000; start = 1'b1;
    @(negedge clk);
    opA = 32'h40000000; opB = 32'hC0000000;  // start still high
    @(negedge clk);
    start = 1'b0;
    check(done && product == 32'h40100000, "R11", "busy start ignored",
          {3'b0, done, product}, {4'b1, 32'h40100000});
    @(negedge clk);
    check(!done, "R11", "no second done", {35'b0, done}, 36'h0);
    repeat (2) @(negedge clk);
    check(!done && product == 32'h40100000, "R11", "result unchanged",
          {3'b0, done, product}, {4'b0, 32'h40100000});

    // R12: reset mid-stream clears outputs
    runOp(32'h7F000000, 32'h40000000, 32'h7F800000, 1'b1, 1'b0, "R5");
    rst_n = 1'b0;
    @(negedge clk);
    check(product == '0 && !ovf && !unf && !done, "R12", "reset clears",
          {1'b0, done, ovf, unf, product}, 36'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule